// File: doc/BRIEF.md
# Two-Channel Serial Controller Register File

This block holds the configuration and status registers of a two-channel serial communications controller and decodes its software reset commands. Software reaches the registers through one command port per channel. It uses indirect addressing: a write to a command port while no register is selected picks a register. The next write to either command port goes to that register, and the selection then clears. A read of a command port returns the selected read register of that port's channel and also clears the selection. One selection pointer serves both ports.

Each channel has sixteen write registers, driven out flat to the serializer, baud and interrupt logic. It also has sixteen read registers, returned on the bus. Two registers are shared by both channels: register 2 holds the interrupt vector and register 9 holds the master control byte. A write to register 9 also carries a two-bit reset command in bits 7:6. The command can reset channel A, channel B or the whole device. A channel-only reset and a whole-device reset load different default values. The `rst_n` input performs a hardware reset and loads the power-on values.

The pointer is controlled by a two-state machine. `ST_SELECT` means no register is selected. `ST_ACCESS` means a register is selected. The transition `SEL_TO_ACC` happens when a command-port write selects a non-zero register. The transition `ACC_TO_SEL` happens when a command-port write or read is made while a register is selected. The transition `SEL_HOLD` happens when a selecting write yields register 0, or on a read while nothing is selected.

Top module: `sercom_regfile`

## Requirements
- R1: While `rst_n` is low and after its release, every write register reads 0x00 except WR4=0x04, WR11=0x08, WR14=0x20 and WR15=0xF8, in both channels. `master_ctl`=0xC0 and `int_vector`=0x00. The read registers are RR0=0x44 and RR1=0x06, and all others are 0x00.
- R2: A command-port write with no register selected changes no register. It sets the pointer to bits 2:0 of the byte, plus 8 when bits 5:3 equal 3'b001.
- R3: A command-port write while register N (N not 2 or 9) is selected stores the full byte into WRN of that port's channel. The selection then clears, so the next write selects again.
- R4: A read of a command port returns, in the same cycle, RR[pointer] of that port's channel, which is RR0 when nothing is selected. The read clears the pointer. Read registers without a defined default read 0x00.
- R5: The pointer is shared. A register selected through one port is written through the other port, and the write lands in the other port's channel.
- R6: A write to register 2 through either port stores the whole byte in `int_vector`. Neither channel's WR2 changes.
- R7: A write to register 9 loads bits 5:0 into `master_ctl[5:0]` and keeps `master_ctl[7:6]`. Neither channel's WR9 changes. Command 2'b00 in bits 7:6 resets nothing.
- R8: Command 2'b10 resets channel A only. In that channel, WR1&=0x24, WR3&=0xFE, WR4|=0x04, WR5&=0x61, WR10&=0x60, WR14=(WR14&0xC3)|0x20 and WR15=0xF8. Also RR0=(RR0&0x3C)|0x44, RR1=0x06, and RR3=RR10=0x00. Channel B is untouched and `master_ctl[5]` ends cleared.
- R9: Command 2'b01 applies the same channel-only reset to channel B, leaves channel A untouched, and clears `master_ctl[5]`.
- R10: Command 2'b11 applies the R8 masks for WR1, WR3, WR4, WR5, WR15 and the read registers to both channels. It also sets WR10=0x00, WR11=0x08 and WR14=(WR14&0xC0)|0x20, and `master_ctl` ends with bits 7:6=11 and bits 1:0=00.
- R11: `bus_addr` 0 is channel A's command port and 1 is channel B's. Accesses at offsets 2 and 3 (data ports) change no register, leave the pointer as it was, and return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 2 | Port offset: 0 cmd A, 1 cmd B, 2/3 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| cfg_a | output | 128 | Channel A write registers, WRn at bits 8n+7:8n |
| cfg_b | output | 128 | Channel B write registers, WRn at bits 8n+7:8n |
| master_ctl | output | 8 | Shared master interrupt control |
| int_vector | output | 8 | Shared interrupt vector |

## Verification
A pointer left in the wrong state shows up on the very next command-port access. A write lands in the wrong register, which is visible on `cfg_a`/`cfg_b` one cycle later, or a read returns the wrong read register in that same cycle. A wrong reset mask becomes visible on the write-register outputs in the cycle after the register-9 write. It is caught by preloading every affected register with ones and zeros before each reset command. A channel-selection error in the reset decode is seen as damage to the channel that should have been left alone.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

    localparam int BYTE_W  = 8;
    localparam int NUM_REG = 16;
    localparam int IDX_W   = $clog2(NUM_REG);
    localparam int FLAT_W  = NUM_REG * BYTE_W;
    localparam int NUM_CH  = 2;

    // shared register slots
    localparam logic [IDX_W-1:0] IDX_VECTOR = IDX_W'(2);
    localparam logic [IDX_W-1:0] IDX_MASTER = IDX_W'(9);

    // pointer-setting byte: bits 5:3 equal to this value add 8
    localparam logic [2:0] PTR_HIGH_CODE = 3'b001;

    typedef enum logic [1:0] {
        RST_NONE = 2'b00,
        RST_CHB  = 2'b01,
        RST_CHA  = 2'b10,
        RST_ALL  = 2'b11
    } rst_cmd_t;

    typedef enum logic {
        ST_SELECT = 1'b0,
        ST_ACCESS = 1'b1
    } ptr_state_t;

    function automatic logic [BYTE_W-1:0] wr_power_on(input int idx);
        unique case (idx)
            4:       return 8'h04;
            11:      return 8'h08;
            14:      return 8'h20;
            15:      return 8'hF8;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] rr_power_on(input int idx);
        unique case (idx)
            0:       return 8'h44;
            1:       return 8'h06;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/sercom_ptr_fsm.sv
module sercom_ptr_fsm
    import sercom_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic             cmd_rd,
    input  logic [5:0]       sel_byte,
    output ptr_state_t       state,
    output logic [IDX_W-1:0] ptr
);

    ptr_state_t       state_n;
    logic [IDX_W-1:0] ptr_n;
    logic [IDX_W-1:0] sel_idx;

    assign sel_idx = {(sel_byte[5:3] == PTR_HIGH_CODE), sel_byte[2:0]};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SELECT;
            ptr   <= '0;
        end else begin
            state <= state_n;
            ptr   <= ptr_n;
        end
    end

    // next state and pointer
    always_comb begin
        state_n = state;
        ptr_n   = ptr;
        unique case (state)
            ST_SELECT: begin
                if (cmd_wr) begin
                    ptr_n   = sel_idx;
                    state_n = (sel_idx != '0) ? ST_ACCESS : ST_SELECT;
                end else if (cmd_rd) begin
                    ptr_n = '0;
                end
            end
            ST_ACCESS: begin
                if (cmd_wr || cmd_rd) begin
                    ptr_n   = '0;
                    state_n = ST_SELECT;
                end
            end
        endcase
    end

    // R4
    ptr_clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd && !cmd_wr) |=> (ptr == '0 && state == ST_SELECT));

    // R3
    ptr_clear_on_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCESS && cmd_wr) |=> (ptr == '0));

    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SELECT && cmd_wr) |=>
            (ptr[2:0] == $past(sel_byte[2:0]) &&
             ptr[IDX_W-1] == ($past(sel_byte[5:3]) == PTR_HIGH_CODE)));

endmodule

// File: rtl/sercom_chan_regs.sv
module sercom_chan_regs
    import sercom_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rst_chan,
    input  logic              rst_full,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_data,
    output logic [FLAT_W-1:0] wr_flat
);

    logic [BYTE_W-1:0] wr_q [NUM_REG];
    logic [BYTE_W-1:0] rr_q [NUM_REG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REG; i++) begin
                wr_q[i] <= wr_power_on(i);
                rr_q[i] <= rr_power_on(i);
            end
        end else if (rst_chan || rst_full) begin
            wr_q[1]  <= wr_q[1] & 8'h24;
            wr_q[3]  <= wr_q[3] & 8'hFE;
            wr_q[4]  <= wr_q[4] | 8'h04;
            wr_q[5]  <= wr_q[5] & 8'h61;
            wr_q[15] <= 8'hF8;
            rr_q[0]  <= (rr_q[0] & 8'h3C) | 8'h44;
            rr_q[1]  <= 8'h06;
            rr_q[3]  <= 8'h00;
            rr_q[10] <= 8'h00;
            if (rst_full) begin
                wr_q[10] <= 8'h00;
                wr_q[11] <= 8'h08;
                wr_q[14] <= (wr_q[14] & 8'hC0) | 8'h20;
            end else begin
                wr_q[10] <= wr_q[10] & 8'h60;
                wr_q[14] <= (wr_q[14] & 8'hC3) | 8'h20;
            end
        end else if (wr_stb) begin
            wr_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = rr_q[rd_idx];

    for (genvar g = 0; g < NUM_REG; g++) begin : g_flat
        assign wr_flat[g*BYTE_W +: BYTE_W] = wr_q[g];
    end

    // R3
    chan_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !rst_chan && !rst_full) |=>
            (wr_q[$past(wr_idx)] == $past(wr_data)));

    // R10
    full_rst_wr11_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_full |=> (wr_q[11] == 8'h08 && wr_q[10] == 8'h00));

    // R8
    chan_rst_wr15_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_chan |=> (wr_q[15] == 8'hF8 && rr_q[1] == 8'h06));

endmodule

// File: rtl/sercom_regfile.sv
module sercom_regfile
    import sercom_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic [FLAT_W-1:0] cfg_a,
    output logic [FLAT_W-1:0] cfg_b,
    output logic [BYTE_W-1:0] master_ctl,
    output logic [BYTE_W-1:0] int_vector
);

    logic             cmd_port;
    logic             port_b;
    logic             cmd_wr;
    logic             cmd_rd;
    ptr_state_t       ptr_state;
    logic [IDX_W-1:0] ptr;
    logic             reg_wr;
    logic             vec_hit;
    logic             mst_hit;
    logic             chan_wr;
    rst_cmd_t         rst_cmd;
    logic             rst_full;
    logic [NUM_CH-1:0] rst_chan;
    logic [BYTE_W-1:0] mst_n;

    logic [FLAT_W-1:0] cfg_arr [NUM_CH];
    logic [BYTE_W-1:0] rd_arr  [NUM_CH];

    assign cmd_port = !bus_addr[1];
    assign port_b   = bus_addr[0];
    assign cmd_wr   = bus_wr && cmd_port;
    assign cmd_rd   = bus_rd && cmd_port && !bus_wr;

    sercom_ptr_fsm u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_rd   (cmd_rd),
        .sel_byte (bus_wdata[5:0]),
        .state    (ptr_state),
        .ptr      (ptr)
    );

    assign reg_wr  = (ptr_state == ST_ACCESS) && cmd_wr;
    assign vec_hit = reg_wr && (ptr == IDX_VECTOR);
    assign mst_hit = reg_wr && (ptr == IDX_MASTER);
    assign chan_wr = reg_wr && !vec_hit && !mst_hit;
    assign rst_cmd = mst_hit ? rst_cmd_t'(bus_wdata[7:6]) : RST_NONE;

    assign rst_full    = (rst_cmd == RST_ALL);
    assign rst_chan[0] = (rst_cmd == RST_CHA);
    assign rst_chan[1] = (rst_cmd == RST_CHB);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        sercom_chan_regs u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_stb   (chan_wr && (port_b == c[0])),
            .wr_idx   (ptr),
            .wr_data  (bus_wdata),
            .rst_chan (rst_chan[c]),
            .rst_full (rst_full),
            .rd_idx   (ptr),
            .rd_data  (rd_arr[c]),
            .wr_flat  (cfg_arr[c])
        );
    end

    assign cfg_a     = cfg_arr[0];
    assign cfg_b     = cfg_arr[1];
    assign bus_rdata = cmd_rd ? rd_arr[port_b] : '0;

    // master control next value
    always_comb begin
        mst_n = {master_ctl[7:6], bus_wdata[5:0]};
        unique case (rst_cmd)
            RST_ALL: begin
                mst_n[7:6] = 2'b11;
                mst_n[1:0] = 2'b00;
            end
            RST_CHA, RST_CHB: mst_n[5] = 1'b0;
            RST_NONE: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            master_ctl <= 8'hC0;
            int_vector <= '0;
        end else begin
            if (mst_hit) master_ctl <= mst_n;
            if (vec_hit) int_vector <= bus_wdata;
        end
    end

    // R6
    vec_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_state == ST_ACCESS && cmd_wr && ptr == IDX_VECTOR) |=>
            (int_vector == $past(bus_wdata)));

    // R7
    mst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_hit && bus_wdata[7:6] == 2'b00) |=>
            (master_ctl == {$past(master_ctl[7:6]), $past(bus_wdata[5:0])}));

    // R10
    full_rst_mst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_full |=> (master_ctl[7:6] == 2'b11 && master_ctl[1:0] == 2'b00));

    // R11
    data_port_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && bus_addr[1]) |=> $stable(ptr));

    // R4
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_rd |-> (bus_rdata == '0));

endmodule

// File: tb/tb_sercom_regfile.sv
module tb_sercom_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [7:0]   bus_wdata = 8'd0;
    logic [7:0]   bus_rdata;
    logic [127:0] cfg_a;
    logic [127:0] cfg_b;
    logic [7:0]   master_ctl;
    logic [7:0]   int_vector;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sercom_regfile dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cfg_a      (cfg_a),
        .cfg_b      (cfg_b),
        .master_ctl (master_ctl),
        .int_vector (int_vector)
    );

    function automatic logic [7:0] wra(input int n);
        return cfg_a[n*8 +: 8];
    endfunction

    function automatic logic [7:0] wrb(input int n);
        return cfg_b[n*8 +: 8];
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic get(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic wreg(input logic [1:0] port, input logic [7:0] sel, input logic [7:0] d);
        put(port, sel);
        put(port, d);
    endtask

    task automatic preload(input logic [1:0] port);
        wreg(port, 8'h01, 8'hFF);
        wreg(port, 8'h03, 8'hFF);
        wreg(port, 8'h04, 8'h00);
        wreg(port, 8'h05, 8'hFF);
        wreg(port, 8'h0A, 8'hFF);
        wreg(port, 8'h0B, 8'h55);
        wreg(port, 8'h0E, 8'hFF);
        wreg(port, 8'h0F, 8'h00);
    endtask

    task automatic t_reset;
        logic [7:0] r;
        check("R1", "A WR4", wra(4), 8'h04);
        check("R1", "B WR11", wrb(11), 8'h08);
        check("R1", "A WR14", wra(14), 8'h20);
        check("R1", "B WR15", wrb(15), 8'hF8);
        check("R1", "A WR3", wra(3), 8'h00);
        check("R1", "master_ctl", master_ctl, 8'hC0);
        check("R1", "int_vector", int_vector, 8'h00);
        get(2'd0, r); check("R1", "A RR0", r, 8'h44);
        put(2'd1, 8'h01);
        get(2'd1, r); check("R1", "B RR1", r, 8'h06);
    endtask

    task automatic t_select_write;
        put(2'd0, 8'h03);
        check("R2", "select leaves A WR3", wra(3), 8'h00);
        put(2'd0, 8'hA5);
        check("R3", "A WR3 stored", wra(3), 8'hA5);
        wreg(2'd0, 8'h05, 8'h3C);
        check("R3", "pointer cleared, A WR5", wra(5), 8'h3C);
        check("R3", "A WR3 kept", wra(3), 8'hA5);
        wreg(2'd0, 8'h0C, 8'h77);
        check("R2", "point-high A WR12", wra(12), 8'h77);
        wreg(2'd0, 8'h08, 8'h11);
        check("R2", "point-high A WR8", wra(8), 8'h11);
        check("R2", "A WR0 untouched", wra(0), 8'h00);
    endtask

    task automatic t_read;
        logic [7:0] r;
        put(2'd0, 8'h01);
        get(2'd0, r); check("R4", "A RR1", r, 8'h06);
        get(2'd0, r); check("R4", "pointer cleared by read", r, 8'h44);
        put(2'd1, 8'h02);
        get(2'd1, r); check("R4", "B RR2 no default", r, 8'h00);
        put(2'd0, 8'h0A);
        get(2'd0, r); check("R4", "A RR10", r, 8'h00);
        put(2'd0, 8'h04);
        put(2'd0, 8'h99);
        check("R4", "read cleared pointer, A WR4 written", wra(4), 8'h99);
    endtask

    task automatic t_shared_ptr;
        logic [7:0] r;
        put(2'd0, 8'h01);
        put(2'd1, 8'h3C);
        check("R5", "B WR1 via shared pointer", wrb(1), 8'h3C);
        check("R5", "A WR1 untouched", wra(1), 8'h00);
        put(2'd1, 8'h01);
        get(2'd0, r); check("R5", "A RR1 via B select", r, 8'h06);
    endtask

    task automatic t_vector;
        wreg(2'd0, 8'h02, 8'h5A);
        check("R6", "vector from A", int_vector, 8'h5A);
        wreg(2'd1, 8'h02, 8'hC3);
        check("R6", "vector from B", int_vector, 8'hC3);
        check("R6", "A WR2", wra(2), 8'h00);
        check("R6", "B WR2", wrb(2), 8'h00);
    endtask

    task automatic t_master;
        wreg(2'd0, 8'h09, 8'h15);
        check("R7", "master 0x15", master_ctl, 8'hD5);
        wreg(2'd1, 8'h09, 8'h3F);
        check("R7", "master 0x3F", master_ctl, 8'hFF);
        check("R7", "A WR9", wra(9), 8'h00);
        check("R7", "B WR9", wrb(9), 8'h00);
        check("R7", "no reset, B WR15", wrb(15), 8'hF8);
    endtask

    task automatic t_chan_a_reset;
        logic [7:0] r;
        preload(2'd0);
        preload(2'd1);
        wreg(2'd0, 8'h09, 8'hA0);
        check("R8", "master", master_ctl, 8'hC0);
        check("R8", "A WR1", wra(1), 8'h24);
        check("R8", "A WR3", wra(3), 8'hFE);
        check("R8", "A WR4", wra(4), 8'h04);
        check("R8", "A WR5", wra(5), 8'h61);
        check("R8", "A WR10", wra(10), 8'h60);
        check("R8", "A WR11 kept", wra(11), 8'h55);
        check("R8", "A WR14", wra(14), 8'hE3);
        check("R8", "A WR15", wra(15), 8'hF8);
        check("R8", "B WR1 untouched", wrb(1), 8'hFF);
        check("R8", "B WR15 untouched", wrb(15), 8'h00);
        put(2'd0, 8'h01);
        get(2'd0, r); check("R8", "A RR1", r, 8'h06);
    endtask

    task automatic t_chan_b_reset;
        wreg(2'd1, 8'h09, 8'h7F);
        check("R9", "master", master_ctl, 8'hDF);
        check("R9", "B WR1", wrb(1), 8'h24);
        check("R9", "B WR10", wrb(10), 8'h60);
        check("R9", "B WR14", wrb(14), 8'hE3);
        check("R9", "B WR15", wrb(15), 8'hF8);
        check("R9", "A WR14 untouched", wra(14), 8'hE3);
        check("R9", "A WR11 untouched", wra(11), 8'h55);
    endtask

    task automatic t_full_reset;
        logic [7:0] r;
        preload(2'd0);
        preload(2'd1);
        wreg(2'd1, 8'h09, 8'hFF);
        check("R10", "master", master_ctl, 8'hFC);
        check("R10", "A WR1", wra(1), 8'h24);
        check("R10", "B WR3", wrb(3), 8'hFE);
        check("R10", "A WR4", wra(4), 8'h04);
        check("R10", "B WR5", wrb(5), 8'h61);
        check("R10", "A WR10", wra(10), 8'h00);
        check("R10", "B WR11", wrb(11), 8'h08);
        check("R10", "A WR14", wra(14), 8'hE0);
        check("R10", "B WR14", wrb(14), 8'hE0);
        check("R10", "A WR15", wra(15), 8'hF8);
        get(2'd1, r); check("R10", "B RR0", r, 8'h44);
    endtask

    task automatic t_data_port;
        logic [7:0]   r;
        logic [127:0] snap_a;
        logic [127:0] snap_b;
        put(2'd0, 8'h05);
        snap_a = cfg_a;
        snap_b = cfg_b;
        put(2'd2, 8'h99);
        put(2'd3, 8'h66);
        get(2'd3, r); check("R11", "data port read", r, 8'h00);
        get(2'd2, r); check("R11", "data port read", r, 8'h00);
        check("R11", "cfg_a unchanged", {7'd0, cfg_a == snap_a}, 8'h01);
        check("R11", "cfg_b unchanged", {7'd0, cfg_b == snap_b}, 8'h01);
        check("R11", "vector unchanged", int_vector, 8'hC3);
        put(2'd0, 8'h42);
        check("R11", "pointer kept, A WR5", wra(5), 8'h42);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 t_reset_held();
        rst_n = 1'b1;
        t_reset();
        t_select_write();
        t_read();
        t_shared_ptr();
        t_vector();
        t_master();
        t_chan_a_reset();
        t_chan_b_reset();
        t_full_reset();
        t_data_port();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic t_reset_held;
        check("R1", "in reset, A WR15", wra(15), 8'hF8);
        check("R1", "in reset, master", master_ctl, 8'hC0);
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog R1-R11 run: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule